// File: doc/BRIEF.md
# Object Attribute Memory Copy Engine

This block copies a fixed run of 160 bytes from the system address space into object attribute memory (OAM). A one-cycle start command carries a 16-bit base address. After a fixed lead-in, the engine opens one transfer slot every few cycles. In each slot it raises a read request on its source port, takes the returned byte in the same cycle, and writes it to the next OAM index.

While a copy is running, the engine sits between the CPU and the rest of the system bus. It lets through only accesses to the high RAM window, 0xFF80 to 0xFFFE. Every other read returns 0xFF without reaching the bus, and every other write is dropped. A busy flag tells the surrounding logic when the copy is in progress.

Top module: `oam_dma_engine`

## Requirements
- R1: A start whose base address is above 0xF100 is ignored: when idle, busy stays low and no OAM write occurs. A base of exactly 0xF100 is accepted.
- R2: An accepted start produces exactly 160 OAM writes. The OAM index runs 0 to 159 and the source address runs from the base to base+159, both stepping by one per byte.
- R3: The first OAM write commits on the 8th clock edge after the edge that samples the start. Each later write commits 4 edges after the previous one.
- R4: While busy, a CPU access to an address outside 0xFF80–0xFFFE does not raise the bus request, and a read returns 0xFF.
- R5: While busy, a CPU access inside 0xFF80–0xFFFE is forwarded to the bus unchanged, and the read data is returned from the bus.
- R6: After the final byte, the engine is idle and every CPU access is forwarded to the bus again.
- R7: An accepted start while busy restarts the copy from the new base, with index 0 and the full lead-in, and drops the remainder of the old copy.
- R8: The busy flag is low after reset. It rises on the edge that samples an accepted start and falls on the edge that commits the 160th byte.
- R9: The source read request and the OAM write are asserted in the same cycle, and the OAM write data equals the source read data of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, one cycle |
| base_i | input | 16 | Source base address for the start command |
| busy_o | output | 1 | Copy in progress |
| src_req_o | output | 1 | Source read request (one per slot) |
| src_addr_o | output | 16 | Source read address |
| src_data_i | input | 8 | Source read data, same cycle as the request |
| oam_we_o | output | 1 | OAM write enable |
| oam_idx_o | output | 8 | OAM byte index |
| oam_data_o | output | 8 | OAM write data |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU write (1) or read (0) |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data |
| bus_req_o | output | 1 | Forwarded bus request |
| bus_we_o | output | 1 | Forwarded write flag |
| bus_addr_o | output | 16 | Forwarded address |
| bus_wdata_o | output | 8 | Forwarded write data |
| bus_rdata_i | input | 8 | Bus read data |

## Verification
The assertions check the following on every cycle:
- the access gating, both the blocking outside high RAM and the forwarding inside it and while idle;
- the single-step advance of the OAM index;
- the bounds on the index;
- that no two slots fall on adjacent cycles;
- the rise and fall of busy around accepted starts and the final byte;
- the rejection of high bases while idle.

Only the bench's scenarios can show the following:
- the exact lead-in and slot spacing measured in edges;
- the full 160-byte address and data sequence against a known source pattern;
- the restart from a new base in the middle of a copy;
- the acceptance of the 0xF100 boundary.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned XFER_LEN    = 160;
  localparam int unsigned FIRST_DELAY = 8;
  localparam int unsigned SLOT_PERIOD = 4;
  localparam logic [ADDR_W-1:0] BASE_LIMIT = 16'hF100;
  localparam logic [ADDR_W-1:0] HRAM_LO    = 16'hFF80;
  localparam logic [ADDR_W-1:0] HRAM_HI    = 16'hFFFE;
  localparam logic [DATA_W-1:0] BLOCK_FILL = 8'hFF;
endpackage

// File: rtl/oam_dma_slot_timer.sv
module oam_dma_slot_timer #(
  parameter int unsigned FIRST_DELAY = 8,
  parameter int unsigned SLOT_PERIOD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic active_i,
  output logic slot_o
);
  localparam int unsigned MAX_D = (FIRST_DELAY > SLOT_PERIOD) ? FIRST_DELAY : SLOT_PERIOD;
  localparam int unsigned CNT_W = $clog2(MAX_D) + 1;

  logic [CNT_W-1:0] cnt_q;

  // a new start suppresses any slot of the transfer it replaces
  assign slot_o = active_i && (cnt_q == '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= CNT_W'(FIRST_DELAY - 1);
    else if (slot_o)                    cnt_q <= CNT_W'(SLOT_PERIOD - 1);
    else if (active_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_SLOT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |=> !slot_o); // R3
  AST_NO_SLOT_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !slot_o); // R3
endmodule

// File: rtl/oam_dma_addr_ctr.sv
module oam_dma_addr_ctr #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned XFER_LEN = 160
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [ADDR_W-1:0]           base_i,
  input  logic                        step_i,
  output logic [ADDR_W-1:0]           src_o,
  output logic [$clog2(XFER_LEN)-1:0] idx_o,
  output logic                        active_o,
  output logic                        last_o
);
  localparam int unsigned IDX_W = $clog2(XFER_LEN);
  localparam int unsigned REM_W = $clog2(XFER_LEN + 1);

  logic [REM_W-1:0]  rem_q;
  logic [ADDR_W-1:0] src_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      src_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      rem_q <= REM_W'(XFER_LEN);
      src_q <= base_i;
      idx_q <= '0;
    end else if (step_i) begin
      rem_q <= rem_q - REM_W'(1);
      src_q <= src_q + ADDR_W'(1);
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign src_o    = src_q;
  assign idx_o    = idx_q;
  assign active_o = (rem_q != '0);
  assign last_o   = (rem_q == REM_W'(1));

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (int'(idx_o) < XFER_LEN)); // R2
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (idx_o == $past(idx_o) + IDX_W'(1))); // R2
  AST_SRC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (src_o == $past(src_o) + ADDR_W'(1))); // R2
endmodule

// File: rtl/oam_dma_cpu_gate.sv
module oam_dma_cpu_gate #(
  parameter int unsigned       ADDR_W  = 16,
  parameter int unsigned       DATA_W  = 8,
  parameter logic [ADDR_W-1:0] HRAM_LO = 16'hFF80,
  parameter logic [ADDR_W-1:0] HRAM_HI = 16'hFFFE,
  parameter logic [DATA_W-1:0] FILL    = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              block_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  logic in_hram, denied;

  assign in_hram     = (cpu_addr_i >= HRAM_LO) && (cpu_addr_i <= HRAM_HI);
  assign denied      = block_i && !in_hram;
  assign bus_req_o   = cpu_req_i && !denied;
  assign bus_we_o    = cpu_we_i;
  assign bus_addr_o  = cpu_addr_i;
  assign bus_wdata_o = cpu_wdata_i;
  assign cpu_rdata_o = denied ? FILL : bus_rdata_i;

  AST_BLOCK_OUTSIDE_HRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_i && cpu_req_i && (cpu_addr_i < HRAM_LO || cpu_addr_i > HRAM_HI))
      |-> (!bus_req_o && cpu_rdata_o == FILL)); // R4
  AST_HRAM_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_addr_i >= HRAM_LO && cpu_addr_i <= HRAM_HI)
      |-> (bus_req_o && cpu_rdata_o == bus_rdata_i)); // R5
  AST_IDLE_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!block_i && cpu_req_i) |-> bus_req_o); // R6
endmodule

// File: rtl/oam_dma_engine.sv
module oam_dma_engine
  import oam_dma_pkg::*;
#(
  parameter int unsigned       XFER_LEN_P    = XFER_LEN,
  parameter int unsigned       FIRST_DELAY_P = FIRST_DELAY,
  parameter int unsigned       SLOT_PERIOD_P = SLOT_PERIOD,
  parameter logic [ADDR_W-1:0] BASE_LIMIT_P  = BASE_LIMIT
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [ADDR_W-1:0]             base_i,
  output logic                          busy_o,
  output logic                          src_req_o,
  output logic [ADDR_W-1:0]             src_addr_o,
  input  logic [DATA_W-1:0]             src_data_i,
  output logic                          oam_we_o,
  output logic [$clog2(XFER_LEN_P)-1:0] oam_idx_o,
  output logic [DATA_W-1:0]             oam_data_o,
  input  logic                          cpu_req_i,
  input  logic                          cpu_we_i,
  input  logic [ADDR_W-1:0]             cpu_addr_i,
  input  logic [DATA_W-1:0]             cpu_wdata_i,
  output logic [DATA_W-1:0]             cpu_rdata_o,
  output logic                          bus_req_o,
  output logic                          bus_we_o,
  output logic [ADDR_W-1:0]             bus_addr_o,
  output logic [DATA_W-1:0]             bus_wdata_o,
  input  logic [DATA_W-1:0]             bus_rdata_i
);
  logic accept, slot, active, last;

  assign accept = start_i && (base_i <= BASE_LIMIT_P);

  oam_dma_addr_ctr #(.ADDR_W(ADDR_W), .XFER_LEN(XFER_LEN_P)) i_addr_ctr (
    .clk_i, .rst_ni,
    .load_i   (accept),
    .base_i   (base_i),
    .step_i   (slot),
    .src_o    (src_addr_o),
    .idx_o    (oam_idx_o),
    .active_o (active),
    .last_o   (last)
  );

  oam_dma_slot_timer #(.FIRST_DELAY(FIRST_DELAY_P), .SLOT_PERIOD(SLOT_PERIOD_P)) i_slot_timer (
    .clk_i, .rst_ni,
    .load_i   (accept),
    .active_i (active),
    .slot_o   (slot)
  );

  oam_dma_cpu_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .HRAM_LO(HRAM_LO), .HRAM_HI(HRAM_HI), .FILL(BLOCK_FILL)
  ) i_cpu_gate (
    .clk_i, .rst_ni,
    .block_i     (active),
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_rdata_o,
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i
  );

  assign busy_o     = active;
  assign src_req_o  = slot;
  assign oam_we_o   = slot;
  assign oam_data_o = src_data_i;

  AST_REJECT_HIGH_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && base_i > BASE_LIMIT_P && !busy_o) |=> !busy_o); // R1
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o); // R8
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oam_we_o && last && !start_i) |=> !busy_o); // R8
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oam_we_o |-> busy_o); // R9
  AST_NO_WRITE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !oam_we_o); // R3
endmodule

// File: tb/test_oam_dma_engine.sv
`timescale 1ns/1ps
module test_oam_dma_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] base_i = '0;
  logic        busy_o, src_req_o, oam_we_o;
  logic [15:0] src_addr_o;
  logic [7:0]  src_data_i, oam_idx_o, oam_data_o;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_wdata_i = 8'h11, cpu_rdata_o;
  logic        bus_req_o, bus_we_o;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_wdata_o;
  logic [7:0]  bus_rdata_i = 8'h5A;

  int checks = 0, failures = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign src_data_i = pat(src_addr_o);

  oam_dma_engine i_oam_dma_engine (.*);

  // write log
  int          wr_cnt = 0, pair_bad = 0;
  int          log_cyc [256];
  logic [7:0]  log_idx [256];
  logic [7:0]  log_dat [256];
  logic [15:0] log_src [256];

  always @(negedge clk_i) begin
    #1;
    if (src_req_o != oam_we_o) pair_bad++;
    if (oam_we_o && wr_cnt < 256) begin
      log_cyc[wr_cnt] = cyc;
      log_idx[wr_cnt] = oam_idx_o;
      log_dat[wr_cnt] = oam_data_o;
      log_src[wr_cnt] = src_addr_o;
      wr_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // address, 1 = reachable while busy
  localparam logic [16:0] VEC [10] = '{
    {16'h0000, 1'b0}, {16'h4000, 1'b0}, {16'h8000, 1'b0}, {16'hC000, 1'b0},
    {16'hFE00, 1'b0}, {16'hFF7F, 1'b0}, {16'hFF80, 1'b1}, {16'hFFC3, 1'b1},
    {16'hFFFE, 1'b1}, {16'hFFFF, 1'b0}};

  task automatic walk_vec(input bit busy_phase);
    for (int i = 0; i < 10; i++) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk_i);
        cpu_req_i = 1'b1; cpu_we_i = w[0]; cpu_addr_i = VEC[i][16:1];
        #1;
        if (busy_phase && !VEC[i][0]) begin
          check(bus_req_o == 1'b0, "R4 bus_req", int'(bus_req_o), 0);
          if (!w[0]) check(cpu_rdata_o == 8'hFF, "R4 rdata", int'(cpu_rdata_o), 8'hFF);
        end else begin
          check(bus_req_o && bus_addr_o == VEC[i][16:1] && bus_we_o == w[0],
                busy_phase ? "R5 pass" : "R6 pass", int'(bus_req_o), 1);
          if (!w[0]) check(cpu_rdata_o == 8'h5A, busy_phase ? "R5 rdata" : "R6 rdata",
                           int'(cpu_rdata_o), 8'h5A);
        end
      end
    end
    @(negedge clk_i);
    cpu_req_i = 1'b0; cpu_we_i = 1'b0;
  endtask

  task automatic do_start(input logic [15:0] b, output int s0);
    @(negedge clk_i);
    start_i = 1'b1; base_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    s0 = cyc;
  endtask

  task automatic wait_idle(output int fall);
    fall = -1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk_i);
      if (!busy_o) begin fall = cyc; break; end
    end
  endtask

  task automatic check_xfer(input logic [15:0] b, input int s0, input int fall);
    int idx_bad = 0, src_bad = 0, dat_bad = 0, tim_bad = 0;
    check(wr_cnt == 160, "R2 count", wr_cnt, 160);
    for (int i = 0; i < 160 && i < wr_cnt; i++) begin
      if (log_idx[i] != 8'(i)) idx_bad++;
      if (log_src[i] != b + 16'(i)) src_bad++;
      if (log_dat[i] != pat(b + 16'(i))) dat_bad++;
      if (log_cyc[i] != s0 + 7 + 4 * i) tim_bad++;
    end
    check(idx_bad == 0, "R2 idx seq", idx_bad, 0);
    check(src_bad == 0, "R2 src seq", src_bad, 0);
    check(dat_bad == 0, "R9 data", dat_bad, 0);
    check(wr_cnt > 0 && log_cyc[0] == s0 + 7, "R3 first", wr_cnt > 0 ? log_cyc[0] - s0 : -1, 7);
    check(tim_bad == 0, "R3 stride", tim_bad, 0);
    check(fall == s0 + 644, "R8 busy fall", fall - s0, 644);
  endtask

  initial begin
    int s0, fall;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0 && oam_we_o == 1'b0, "R8 reset", int'(busy_o), 0);

    // normal copy with blackout walk
    wr_cnt = 0;
    do_start(16'hC000, s0);
    check(busy_o == 1'b1, "R8 busy rise", int'(busy_o), 1);
    walk_vec(1'b1);
    wait_idle(fall);
    check_xfer(16'hC000, s0, fall);
    walk_vec(1'b0);

    // base above limit
    wr_cnt = 0;
    do_start(16'hF101, s0);
    repeat (20) @(negedge clk_i);
    check(busy_o == 1'b0, "R1 reject busy", int'(busy_o), 0);
    check(wr_cnt == 0, "R1 reject writes", wr_cnt, 0);

    // boundary base
    wr_cnt = 0;
    do_start(16'hF100, s0);
    check(busy_o == 1'b1, "R1 boundary accept", int'(busy_o), 1);
    wait_idle(fall);
    check_xfer(16'hF100, s0, fall);
    check(wr_cnt > 159 && log_src[159] == 16'hF19F, "R2 last src",
          wr_cnt > 159 ? int'(log_src[159]) : -1, 16'hF19F);

    // restart mid-copy
    wr_cnt = 0;
    do_start(16'h8000, s0);
    while (wr_cnt < 10) @(negedge clk_i);
    @(negedge clk_i);
    start_i = 1'b1; base_i = 16'h4000;
    wr_cnt = 0;
    @(negedge clk_i);
    start_i = 1'b0;
    s0 = cyc;
    check(busy_o == 1'b1, "R7 still busy", int'(busy_o), 1);
    wait_idle(fall);
    check_xfer(16'h4000, s0, fall);
    check(wr_cnt > 0 && log_src[0] == 16'h4000, "R7 new base",
          wr_cnt > 0 ? int'(log_src[0]) : -1, 16'h4000);

    check(pair_bad == 0, "R9 req/we pairing", pair_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule